// File: doc/BRIEF.md
# Latched-Address Inverting Select Decoder

This block turns a small binary address into a set of active-low select lines, exactly one of which is driven LOW when the block is enabled. An address hold stage sits in front of the decoder. While the hold request is LOW the stage is transparent, and the select lines follow the live address. When the hold request rises, the address that was present before that edge is kept. Later address changes are ignored for as long as the hold request stays HIGH.

Two output qualifiers gate every select line, one active-low and one active-high. Unless both are in their active state, all select lines are HIGH. The qualifiers do not touch the stored address, so a held selection comes back unchanged when the block is enabled again.

The hold stage is a clocked sample, which makes it synthesizable. On every clock edge where the hold request is LOW, the stage stores the live address. The select outputs are combinational from the live address, the stored address, the hold request and the qualifiers.

Top module: `latdec_inv`

## Requirements
- R1: A synchronous reset (rst_n LOW at a clock edge) clears the stored address to 0. If hold_req is HIGH from reset onward and the block is enabled, sel_n reads 8'hFE.
- R2: While hold_req is LOW and the block is enabled, sel_n equals the inverse of a one-hot vector indexed by the live sel_addr, with no added cycle of delay.
- R3: In the first cycle that hold_req is HIGH after being LOW at the previous clock edge, the effective address is the sel_addr value from the previous cycle. An address change in that same cycle has no effect.
- R4: While hold_req stays HIGH, changes on sel_addr have no effect on sel_n.
- R5: All bits of sel_n are HIGH unless en_n is LOW and en_p is HIGH, whatever the address or hold state.
- R6: Toggling en_n and en_p while hold_req is HIGH does not change the stored address. On re-enable, sel_n shows the same held decode as before.
- R7: At most one bit of sel_n is LOW at any time. When the block is enabled, exactly one bit is LOW.
- R8: Bit n of sel_n corresponds to address value n, with sel_addr[0] as the least significant bit. For example, address 2 gives 8'hFB and address 7 gives 8'h7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the address hold stage |
| rst_n | input | 1 | Synchronous active-low reset; clears the stored address |
| sel_addr | input | 3 | Binary address to decode |
| hold_req | input | 1 | LOW: transparent; HIGH: keep the captured address |
| en_n | input | 1 | Active-low output qualifier |
| en_p | input | 1 | Active-high output qualifier |
| sel_n | output | 8 | Active-low select lines, bit n selected by address n |

## Verification
The hardest case to reach from the ports is the capture cycle. There, hold_req rises in the same cycle that sel_addr moves to a new value, so the decoder has to show the old address and not the new one. The stimulus places a known address for one cycle and then raises hold_req and changes the address together. It then cycles both qualifiers through all four combinations while still holding, to show that the held decode returns. A long randomized phase repeats these edges against a behavioural model that keeps a queue of the addresses seen while transparent.

// File: rtl/latdec_pkg.sv
// Shared types for the latched-address inverting decoder.
// Assumes: two output qualifiers of opposite polarity.
package latdec_pkg;

    // Pair of output qualifiers in their raw port polarity.
    typedef struct packed {
        logic act_low;
        logic act_high;
    } qual_pair_t;

    // True when both qualifiers are in their active state.
    function automatic logic qual_pass(qual_pair_t q);
        return (!q.act_low) && q.act_high;
    endfunction

endpackage

// File: rtl/addr_hold_stage.sv
// Address hold stage: stores the live address on every clock edge where
// the hold request is low, and keeps it otherwise. The effective address is
// the live address while transparent and the stored one while holding.
// Assumes: synchronous active-low reset clears the stored address.
module addr_hold_stage #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              hold,
    output logic [ADDR_W-1:0] addr_eff
);
    logic [ADDR_W-1:0] stored_q;

    // Sample the address while transparent; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_q <= '0;
        end else if (!hold) begin
            stored_q <= addr_in;
        end
    end

    // Pick the live or the stored address.
    always_comb begin
        addr_eff = hold ? stored_q : addr_in;
    end
endmodule

// File: rtl/qual_gate.sv
// Output qualifier: combines the two enables of opposite polarity into a
// single active-high pass signal.
// Assumes: nothing beyond the package type.
module qual_gate
    import latdec_pkg::*;
(
    input  qual_pair_t quals,
    output logic       pass
);
    // Reduce the qualifier pair to one pass flag.
    always_comb begin
        pass = qual_pass(quals);
    end
endmodule

// File: rtl/inv_decoder.sv
// Inverting binary decoder: drives the one line whose index equals the
// address LOW when passed, and all lines HIGH otherwise.
// Assumes: NUM_OUT equals 2**ADDR_W.
module inv_decoder #(
    parameter int ADDR_W  = 3,
    parameter int NUM_OUT = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               pass,
    output logic [NUM_OUT-1:0] lines_n
);
    // One comparator per output line.
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_line
        always_comb begin
            lines_n[i] = !(pass && (addr == ADDR_W'(i)));
        end
    end
endmodule

// File: rtl/latdec_inv.sv
// Top of the latched-address inverting decoder: hold stage, qualifier
// gate and inverting decoder in series.
// Assumes: inputs are synchronous to clk; outputs are combinational.
module latdec_inv
    import latdec_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int NUM_OUT = 1 << ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  sel_addr,
    input  logic               hold_req,
    input  logic               en_n,
    input  logic               en_p,
    output logic [NUM_OUT-1:0] sel_n
);
    logic [ADDR_W-1:0] addr_eff;
    logic              pass;
    qual_pair_t        quals;

    // Pack the raw qualifier pins.
    always_comb begin
        quals.act_low  = en_n;
        quals.act_high = en_p;
    end

    addr_hold_stage #(.ADDR_W(ADDR_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_in  (sel_addr),
        .hold     (hold_req),
        .addr_eff (addr_eff)
    );

    qual_gate u_qual (
        .quals (quals),
        .pass  (pass)
    );

    inv_decoder #(.ADDR_W(ADDR_W), .NUM_OUT(NUM_OUT)) u_dec (
        .addr    (addr_eff),
        .pass    (pass),
        .lines_n (sel_n)
    );
endmodule

// File: rtl/latdec_inv_chk.sv
// Checker for latdec_inv: port-level temporal properties, bound to the top.
// Assumes: synchronous active-low reset.
module latdec_inv_chk #(
    parameter int ADDR_W = 3,
    localparam int NUM_OUT = 1 << ADDR_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  sel_addr,
    input logic               hold_req,
    input logic               en_n,
    input logic               en_p,
    input logic [NUM_OUT-1:0] sel_n
);
    logic on;
    logic primed;

    // Flag when both qualifiers are active.
    always_comb begin
        on = !en_n && en_p;
    end

    // Mark one full cycle out of reset so $past sees defined values.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    assert_mutex_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n) && (on -> ($countones(~sel_n) == 1)));

    assert_gate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !on |-> (sel_n == {NUM_OUT{1'b1}}));

    assert_transparent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_req && on) |-> (sel_n == ~(NUM_OUT'(1) << sel_addr)));

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && hold_req && !$past(hold_req) && on)
            |-> (sel_n == ~(NUM_OUT'(1) << $past(sel_addr))));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && hold_req && $past(hold_req) && on && $past(on)) |-> $stable(sel_n));
endmodule

bind latdec_inv latdec_inv_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_addr (sel_addr),
    .hold_req (hold_req),
    .en_n     (en_n),
    .en_p     (en_p),
    .sel_n    (sel_n)
);

// File: tb/latdec_inv_bench.sv
// Bench for latdec_inv: behavioural reference compared on every clock.
module latdec_inv_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel_addr = 3'd5;
    logic       hold_req = 1'b1;
    logic       en_n = 1'b0;
    logic       en_p = 1'b1;
    logic [7:0] sel_n;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";
    int    seen[$];          // addresses observed while transparent
    bit    done = 1'b0;

    always #2 clk = ~clk;

    latdec_inv u_latdec_inv (
        .clk(clk), .rst_n(rst_n), .sel_addr(sel_addr), .hold_req(hold_req),
        .en_n(en_n), .en_p(en_p), .sel_n(sel_n)
    );

    // Reference: remember what the address was at each transparent edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            seen.delete();
            seen.push_back(0);
        end else if (!hold_req) begin
            seen.push_back(int'(sel_addr));
            if (seen.size() > 8) void'(seen.pop_front());
        end
    end

    function automatic logic [7:0] expect_out();
        int a;
        if (!(en_n == 1'b0 && en_p == 1'b1)) return 8'hFF;
        a = hold_req ? seen[$] : int'(sel_addr);
        return ~(8'(1) << a);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: sel_n=%h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare away from the active edge, every cycle after reset.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(tag, sel_n, expect_out());
            if ($countones(~sel_n) > 1) check("R7", sel_n, 8'hFF);
        end
    end

    task automatic step(logic [2:0] a, logic h, logic e0, logic e1);
        @(posedge clk); #1;
        sel_addr = a; hold_req = h; en_n = e0; en_p = e1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: held from reset with a nonzero live address
        tag = "R1";
        step(3'd6, 1'b1, 1'b0, 1'b1);
        @(negedge clk); check("R1", sel_n, 8'hFE);
        // R2/R8: transparent sweep
        tag = "R2";
        for (int i = 0; i < 8; i++) step(3'(i), 1'b0, 1'b0, 1'b1);
        step(3'd2, 1'b0, 1'b0, 1'b1);
        @(negedge clk); check("R8", sel_n, 8'hFB);
        step(3'd7, 1'b0, 1'b0, 1'b1);
        @(negedge clk); check("R8", sel_n, 8'h7F);
        // R3: address moves in the same cycle the hold rises
        tag = "R3";
        step(3'd3, 1'b0, 1'b0, 1'b1);
        step(3'd6, 1'b1, 1'b0, 1'b1);
        @(negedge clk); check("R3", sel_n, 8'hF7);
        // R4: address changes while holding
        tag = "R4";
        for (int i = 0; i < 8; i++) begin
            step(3'(7 - i), 1'b1, 1'b0, 1'b1);
            @(negedge clk); check("R4", sel_n, 8'hF7);
        end
        // R5/R6: qualifier combinations while holding
        tag = "R5";
        for (int i = 0; i < 4; i++) begin
            step(3'(i), 1'b1, i[0], i[1]);
            @(negedge clk);
            check("R5", sel_n, (i == 2) ? 8'hF7 : 8'hFF);
        end
        tag = "R6";
        step(3'd1, 1'b1, 1'b0, 1'b1);
        @(negedge clk); check("R6", sel_n, 8'hF7);
        // Random mix, every requirement against the model
        tag = "R7";
        for (int i = 0; i < 400; i++)
            step(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) != 0));
        @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule